// File: doc/BRIEF.md
# Configuration Change Scanner and Dispatcher

This block keeps the detector's settings in step with a small configuration RAM that the host rewrites at will. The host's writes do not reach the detector directly. The block walks the RAM one address at a time, without end. It compares each word it reads with a shadow copy of the last value it forwarded for that address. When the two differ, it offers the address and the new word to a serial sender. Once the sender takes the offer, the shadow entry for that address is updated to the word that was sent.

The RAM read port is synchronous. The block raises `ram_rd_en` with an address, and the word arrives on `ram_rd_data` in the next cycle. Each address therefore takes one read cycle and one compare cycle.

The command output is a valid/ready stream. While `cmd_valid` is high, `cmd_addr` and `cmd_data` stay frozen and the scan stalls: it issues no reads until the sender raises `cmd_ready`. The sender can apply back-pressure for as long as it needs, and no change is lost or duplicated.

Top module: `cfg_delta_dispatch`

## Requirements
- R1: Out of reset, `cmd_valid` is low and every shadow entry is zero. A RAM that holds only zeros therefore never produces a command.
- R2: Read requests step through the addresses 0, 1, …, N-1 and then wrap back to 0. The first request after reset is address 0. When no command is pending, `ram_rd_en` is high in every other cycle, and a read cycle is never followed directly by another read cycle.
- R3: A nonzero word written to an address after reset is offered on the command stream with that address and that word.
- R4: A word equal to the last value sent for its address is never offered again, however many scan passes run.
- R5: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high, `cmd_addr` and `cmd_data` do not change, and `ram_rd_en` stays low.
- R6: In the cycle after a handshake (`cmd_valid` and `cmd_ready` both high at a clock edge), a read is issued for the next address after `cmd_addr`. After address N-1 the next address is 0.
- R7: If the host rewrites an address while that address's command is still waiting for `cmd_ready`, the pending command keeps the old word. The newer word is offered on a later pass.
- R8: Writing zero back to an address whose last sent value was nonzero produces a command carrying zero.
- R9: When several addresses change at once, each of them is offered exactly once, and the stream then goes quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ram_rd_en | output | 1 | Read request to the configuration RAM |
| ram_rd_addr | output | AW | Address being read |
| ram_rd_data | input | DW | RAM word, valid the cycle after `ram_rd_en` |
| cmd_valid | output | 1 | A changed entry is on offer |
| cmd_ready | input | 1 | The serial sender accepts the offer |
| cmd_addr | output | AW | Address of the offered entry |
| cmd_data | output | DW | New word for that address |

## Verification
The bench builds the block with eight entries of 16 bits. With eight entries, a full scan pass takes only sixteen cycles. That makes it cheap to run several passes to prove nothing is re-sent. It also lets the bench reach the wrap from the last address back to address 0, both during a plain scan and right after a handshake. The bench's RAM model is updated at the falling edge. This lets it rewrite an entry while that entry's command is stalled, and write two entries in the same cycle.

// File: rtl/cfgd_pkg.sv
package cfgd_pkg;
  typedef enum logic [1:0] {
    SC_READ  = 2'd0,
    SC_CHECK = 2'd1,
    SC_OFFER = 2'd2
  } scan_state_e;
endpackage

// File: rtl/cfgd_scan_ptr.sv
module cfgd_scan_ptr #(
  parameter int N  = 8,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(N - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/cfgd_shadow.sv
module cfgd_shadow #(
  parameter int N  = 8,
  parameter int AW = $clog2(N),
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] entry [N];

  for (genvar g = 0; g < N; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                           entry[g] <= '0;
      else if (wr_en && wr_addr == AW'(g))  entry[g] <= wr_data;
    end
  end

  assign rd_data = entry[rd_addr];
endmodule

// File: rtl/cfgd_ctrl.sv
module cfgd_ctrl
  import cfgd_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ptr,
  input  logic [DW-1:0] rd_value,
  input  logic [DW-1:0] shadow_value,
  input  logic          cmd_ready,
  output logic          ram_rd_en,
  output logic          advance,
  output logic          shadow_we,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);
  scan_state_e state;
  logic        differ;

  assign differ    = (rd_value != shadow_value);
  assign ram_rd_en = (state == SC_READ);
  assign cmd_valid = (state == SC_OFFER);
  assign shadow_we = (state == SC_OFFER) && cmd_ready;
  assign advance   = ((state == SC_CHECK) && !differ) || shadow_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SC_READ;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      case (state)
        SC_READ:  state <= SC_CHECK;
        SC_CHECK: begin
          if (differ) begin
            cmd_addr <= ptr;
            cmd_data <= rd_value;
            state    <= SC_OFFER;
          end else begin
            state <= SC_READ;
          end
        end
        SC_OFFER: if (cmd_ready) state <= SC_READ;
        default:  state <= SC_READ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_delta_dispatch.sv
module cfg_delta_dispatch #(
  parameter int N  = 8,
  parameter int DW = 16,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          ram_rd_en,
  output logic [AW-1:0] ram_rd_addr,
  input  logic [DW-1:0] ram_rd_data,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);
  logic [AW-1:0] ptr;
  logic          advance;
  logic          shadow_we;
  logic [DW-1:0] shadow_value;

  cfgd_scan_ptr #(.N(N), .AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .advance(advance), .ptr(ptr)
  );

  cfgd_shadow #(.N(N), .AW(AW), .DW(DW)) u_shadow (
    .clk(clk), .rst_n(rst_n),
    .wr_en(shadow_we), .wr_addr(cmd_addr), .wr_data(cmd_data),
    .rd_addr(ptr), .rd_data(shadow_value)
  );

  cfgd_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ptr(ptr),
    .rd_value(ram_rd_data), .shadow_value(shadow_value),
    .cmd_ready(cmd_ready), .ram_rd_en(ram_rd_en), .advance(advance),
    .shadow_we(shadow_we), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  assign ram_rd_addr = ptr;
endmodule

// File: rtl/cfg_delta_dispatch_chk.sv
module cfg_delta_dispatch_chk #(
  parameter int N  = 8,
  parameter int DW = 16,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ram_rd_en,
  input logic [AW-1:0] ram_rd_addr,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [AW-1:0] cmd_addr,
  input logic [DW-1:0] cmd_data
);
  localparam logic [AW-1:0] LAST = AW'(N - 1);

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_data)); // R5
  AST_NO_READ_WHILE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !ram_rd_en); // R5
  AST_READ_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_en |=> !ram_rd_en); // R2
  AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_en |-> ram_rd_addr <= LAST); // R2
  AST_RESUME_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> ram_rd_en &&
      ram_rd_addr == (($past(cmd_addr) == LAST) ? '0 : $past(cmd_addr) + 1'b1)); // R6
endmodule

bind cfg_delta_dispatch cfg_delta_dispatch_chk #(.N(N), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
);

// File: tb/cfg_delta_dispatch_tb_top.sv
module cfg_delta_dispatch_tb_top;
  localparam int N  = 8;
  localparam int DW = 16;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ram_rd_en;
  logic [AW-1:0] ram_rd_addr;
  logic [DW-1:0] ram_rd_data;
  logic          cmd_valid;
  logic          cmd_ready = 1'b0;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic [DW-1:0] mem [N];

  int n_tests = 0;
  int n_fail  = 0;
  int n_hs    = 0;

  always #5 clk = ~clk;

  cfg_delta_dispatch #(.N(N), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr),
    .ram_rd_data(ram_rd_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  always_ff @(posedge clk) if (ram_rd_en) ram_rd_data <= mem[ram_rd_addr];
  always_ff @(posedge clk) if (rst_n && cmd_valid && cmd_ready) n_hs <= n_hs + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_valid(output bit seen);
    seen = 0;
    for (int i = 0; i < 8 * N; i++) begin
      @(negedge clk);
      if (cmd_valid) begin seen = 1; break; end
    end
  endtask

  // Accept the pending offer, then check where the scan resumes (R6).
  task automatic accept_and_check_resume(input int exp_next);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    check(ram_rd_en && int'(ram_rd_addr) == exp_next, "R6 resume addr",
          ram_rd_en ? int'(ram_rd_addr) : -1, exp_next);
  endtask

  task automatic quiet_window(input string req, input int passes);
    int base;
    base = n_hs;
    cmd_ready = 1'b1;
    repeat (passes * 2 * N) @(negedge clk);
    cmd_ready = 1'b0;
    check(n_hs == base, req, n_hs - base, 0);
  endtask

  task automatic t_reset_and_scan();
    int exp_a;
    int reads;
    bit prev;
    check(!cmd_valid, "R1 valid low at reset", cmd_valid, 0);
    exp_a = 0; reads = 0; prev = 0;
    for (int i = 0; i < 4 * N; i++) begin
      if (ram_rd_en) begin
        check(int'(ram_rd_addr) == exp_a, "R2 scan order", ram_rd_addr, exp_a);
        check(!prev, "R2 back-to-back read", 1, 0);
        exp_a = (exp_a + 1) % N;
        reads++;
      end
      prev = ram_rd_en;
      @(negedge clk);
    end
    check(reads == 2 * N, "R2 read count", reads, 2 * N);
    quiet_window("R1 zero RAM quiet", 3);
  endtask

  task automatic t_single();
    bit seen;
    mem[3] = 16'hA5A5;
    wait_valid(seen);
    check(seen && cmd_addr == 3 && cmd_data == 16'hA5A5, "R3 dispatch",
          {cmd_addr, cmd_data}, {3'd3, 16'hA5A5});
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(cmd_valid && !ram_rd_en && cmd_addr == 3 && cmd_data == 16'hA5A5,
            "R5 held offer", {cmd_valid, ram_rd_en, cmd_data}, {2'b10, 16'hA5A5});
    end
    accept_and_check_resume(4);
    quiet_window("R4 no resend", 3);
  endtask

  task automatic t_wrap();
    bit seen;
    mem[N-1] = 16'h1234;
    wait_valid(seen);
    check(seen && cmd_addr == 3'(N-1) && cmd_data == 16'h1234, "R3 last addr",
          cmd_data, 16'h1234);
    accept_and_check_resume(0);
  endtask

  task automatic t_inflight();
    bit seen;
    mem[5] = 16'h0011;
    wait_valid(seen);
    check(seen && cmd_addr == 5, "R3 inflight first", cmd_addr, 5);
    mem[5] = 16'h0022;
    repeat (3) @(negedge clk);
    check(cmd_data == 16'h0011, "R7 keeps old word", cmd_data, 16'h0011);
    accept_and_check_resume(6);
    wait_valid(seen);
    check(seen && cmd_addr == 5 && cmd_data == 16'h0022, "R7 newer word later",
          cmd_data, 16'h0022);
    accept_and_check_resume(6);
  endtask

  task automatic t_back_to_zero();
    bit seen;
    mem[3] = '0;
    wait_valid(seen);
    check(seen && cmd_addr == 3 && cmd_data == 16'h0000, "R8 zero sent",
          cmd_data, 0);
    accept_and_check_resume(4);
  endtask

  task automatic t_multi();
    bit seen;
    bit got1, got6;
    got1 = 0; got6 = 0;
    mem[1] = 16'h0007;
    mem[6] = 16'h0009;
    for (int k = 0; k < 2; k++) begin
      wait_valid(seen);
      check(seen, "R9 offer seen", seen, 1);
      if (cmd_addr == 1 && cmd_data == 16'h0007 && !got1) got1 = 1;
      else if (cmd_addr == 6 && cmd_data == 16'h0009 && !got6) got6 = 1;
      else check(0, "R9 unexpected offer", {cmd_addr, cmd_data}, 0);
      accept_and_check_resume((int'(cmd_addr) + 1) % N);
    end
    check(got1 && got6, "R9 both sent", {got1, got6}, 2'b11);
    quiet_window("R9 quiet after", 3);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_and_scan();
    t_single();
    t_wrap();
    t_inflight();
    t_back_to_zero();
    t_multi();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule